// File: doc/BRIEF.md
# Translation Buffer with Hardware Table Walker

The block turns virtual addresses into physical addresses for a paged memory system with 8 KB pages. The low 13 bits of an address, the page offset, pass through unchanged. The virtual page number is looked up in a small, fully associative buffer of recent translations. When the buffer holds a translation, the physical address is returned in the same cycle as the request.

When the lookup misses, a walker state machine takes over. It computes the address of the page table entry from a table base input and the virtual page number. It reads that single word through a memory read port. If the entry marks the page present, the walker writes the translation into the buffer and replays the lookup, which now hits. If the entry marks the page absent, the walker raises a fault output and installs nothing. The fault output stays high until it is acknowledged.

Replacement is least recently used, and empty entries are always filled first. A flush input empties the whole buffer in one cycle. The walker has five states:
- `W_IDLE`: accepts requests.
- `W_ISSUE`: issues the memory read.
- `W_WAIT`: waits for the read data.
- `W_REPLAY`: returns the translated address.
- `W_FAULT`: holds the fault.

The transitions are:
- idle to issue on a miss.
- issue to wait unconditionally.
- wait to replay on a present entry.
- wait to fault on an absent entry.
- replay to idle unconditionally.
- fault to idle on acknowledge.

Top module: `xlat_unit`

## Requirements
- R1: In `W_IDLE`, a request whose page is in the buffer gets `rsp_valid` high in the same cycle. `rsp_paddr` is the stored physical page number in bits [31:13] and `req_vaddr[12:0]` in bits [12:0].
- R2: Any virtual page number, including ones with high bits set, can sit in any entry. At most one entry ever matches a lookup.
- R3: A miss in `W_IDLE` moves the walker to `W_ISSUE`. In the next cycle, `mem_rd_en` is high for exactly one cycle with `mem_rd_addr = tbl_base + vpn*4`.
- R4: A page table entry is present when bit 0 is 1. Bits [31:13] hold the physical page number, and bits [12:1] are ignored. For a present entry, the translation is installed and the replay responds two cycles plus the memory latency after the request cycle. That is, `rsp_valid` is high in the cycle after `mem_rd_valid`.
- R5: An entry with bit 0 equal to 0 raises `fault` in the cycle after `mem_rd_valid`. No response is given and no entry is installed, so a later request to the same page walks again.
- R6: `fault` stays high, with `req_ready` low, until `fault_ack` is seen. In the following cycle `fault` is low and `req_ready` is high.
- R7: Invalid entries are filled before any valid entry is replaced. When the buffer is full, a new translation replaces the entry least recently used by a hit or an install.
- R8: A cycle with `flush_all` high clears every valid bit, so each previously cached page misses afterwards.
- R9: `req_ready` is low in every state except `W_IDLE`. A request presented during a walk has no effect: there is no extra memory read, and the response carries the original address.
- R10: After reset, `req_ready` is high and `rsp_valid`, `fault` and `mem_rd_en` are low. The buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | Translated address is valid |
| rsp_paddr | output | 32 | Physical address |
| tbl_base | input | 32 | Base address of the page table |
| flush_all | input | 1 | Invalidate every buffer entry |
| mem_rd_en | output | 1 | Memory read request, one cycle |
| mem_rd_addr | output | 32 | Address of the page table entry |
| mem_rd_valid | input | 1 | Read data is valid |
| mem_rd_data | input | 32 | Page table entry word |
| fault | output | 1 | Page not present, held until acknowledged |
| fault_ack | input | 1 | Acknowledge and clear the fault |

## Verification
The hardest case to reach from the ports is an eviction of one specific entry. It needs a full buffer whose least recently used order is known exactly, followed by a miss on a new page that is present in the table.

The stimulus cycles through 24 pages, five of them absent, against 16 entries, in a stride pattern that revisits pages at irregular distances. An ordered list in the bench models recency and predicts every hit, miss and fault. Some walks carry a stray request on the inputs, and a flush in the middle of the run returns the buffer to its invalid-first filling.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [2:0] {
        W_IDLE,
        W_ISSUE,
        W_WAIT,
        W_REPLAY,
        W_FAULT
    } walk_state_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 19,
    parameter int PPN_W   = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             use_en,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             flush,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [VPN_W-1:0] tag_q [ENTRIES];
    logic [PPN_W-1:0] ppn_q [ENTRIES];
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0] hit_idx, victim, touch_idx, touch_age;
    logic touch_en;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match[g] = valid_q[g] && (tag_q[g] == look_vpn);
    end

    assign hit = |match;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit_ppn = ppn_q[hit_idx];

    // victim: lowest invalid entry first, otherwise the oldest entry
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_q[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == OLDEST) victim = IDX_W'(i);
            end
        end
    end

    assign touch_en  = wr_en || (use_en && hit);
    assign touch_idx = wr_en ? victim : hit_idx;
    assign touch_age = age_q[touch_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (touch_en) begin
                    if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
                    else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
                end
                if (wr_en && (IDX_W'(i) == victim)) valid_q[i] <= 1'b1;
                else if (flush) valid_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (IDX_W'(i) == victim)) begin
                tag_q[i] <= wr_vpn;
                ppn_q[i] <= wr_ppn;
            end
        end
    end

    // R2: a lookup never matches more than one entry
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R8: a flush with no install leaves nothing valid
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !wr_en |=> valid_q == '0);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 13,
    parameter int PPN_W = 19,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_vaddr,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic [PPN_W+OFF_W-1:0] rsp_paddr,
    input  logic [AW-1:0]          tbl_base,
    output logic                   mem_rd_en,
    output logic [AW-1:0]          mem_rd_addr,
    input  logic                   mem_rd_valid,
    input  logic [DW-1:0]          mem_rd_data,
    output logic                   fault,
    input  logic                   fault_ack,
    output logic [VA_W-OFF_W-1:0]  look_vpn,
    input  logic                   hit,
    input  logic [PPN_W-1:0]       hit_ppn,
    output logic                   use_en,
    output logic                   wr_en,
    output logic [VA_W-OFF_W-1:0]  wr_vpn,
    output logic [PPN_W-1:0]       wr_ppn
);
    localparam int VPN_W = VA_W - OFF_W;

    walk_state_e state_q, state_d;
    logic [VA_W-1:0] va_q;
    logic [OFF_W-1:0] cur_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) va_q <= '0;
        else if (state_q == W_IDLE && req_valid) va_q <= req_vaddr;
    end

    assign mem_rd_addr = tbl_base + (AW'(va_q[VA_W-1:OFF_W]) << 2);
    assign wr_vpn      = va_q[VA_W-1:OFF_W];
    assign wr_ppn      = mem_rd_data[OFF_W+PPN_W-1:OFF_W];
    assign rsp_paddr   = {hit_ppn, cur_off};

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        use_en    = 1'b0;
        wr_en     = 1'b0;
        mem_rd_en = 1'b0;
        fault     = 1'b0;
        look_vpn  = va_q[VA_W-1:OFF_W];
        cur_off   = va_q[OFF_W-1:0];
        unique case (state_q)
            W_IDLE: begin
                req_ready = 1'b1;
                look_vpn  = req_vaddr[VA_W-1:OFF_W];
                cur_off   = req_vaddr[OFF_W-1:0];
                if (req_valid) begin
                    if (hit) begin
                        rsp_valid = 1'b1;
                        use_en    = 1'b1;
                    end else begin
                        state_d = W_ISSUE;
                    end
                end
            end
            W_ISSUE: begin
                mem_rd_en = 1'b1;
                state_d   = W_WAIT;
            end
            W_WAIT: begin
                if (mem_rd_valid) begin
                    if (mem_rd_data[0]) begin
                        wr_en   = 1'b1;
                        state_d = W_REPLAY;
                    end else begin
                        state_d = W_FAULT;
                    end
                end
            end
            W_REPLAY: begin
                rsp_valid = 1'b1;
                use_en    = 1'b1;
                state_d   = W_IDLE;
            end
            W_FAULT: begin
                fault = 1'b1;
                if (fault_ack) state_d = W_IDLE;
            end
            default: state_d = W_IDLE;
        endcase
    end

    // R3: one memory read per walk
    p_issue_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R4: the replayed lookup finds the installed translation
    p_replay_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == W_REPLAY |-> hit);

    // R4: a response outside idle follows a present entry from memory
    p_replay_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !req_ready |-> $past(mem_rd_valid && mem_rd_data[0]));

    // R5: a fault starts only after an absent entry is read
    p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(mem_rd_valid) && !$past(mem_rd_data[0]));

    // R6: the fault holds until acknowledged
    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !fault_ack |=> fault);
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 13,
    parameter int ENTRIES = 16,
    parameter int AW      = 32,
    parameter int DW      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            req_ready,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    input  logic [AW-1:0]   tbl_base,
    input  logic            flush_all,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [DW-1:0]   mem_rd_data,
    output logic            fault,
    input  logic            fault_ack
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    logic [VPN_W-1:0] look_vpn, wr_vpn;
    logic [PPN_W-1:0] hit_ppn, wr_ppn;
    logic hit, use_en, wr_en;

    xlat_cam #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
    ) u_cam (
        .clk(clk), .rst_n(rst_n), .look_vpn(look_vpn), .use_en(use_en),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .flush(flush_all),
        .hit(hit), .hit_ppn(hit_ppn)
    );

    xlat_walker #(
        .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .AW(AW), .DW(DW)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .tbl_base(tbl_base), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .fault(fault),
        .fault_ack(fault_ack), .look_vpn(look_vpn), .hit(hit), .hit_ppn(hit_ppn),
        .use_en(use_en), .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn)
    );
endmodule

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
    localparam int LAT = 3;
    localparam int NENT = 16;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, flush_all = 1'b0, fault_ack = 1'b0;
    logic [31:0] req_vaddr = '0, tbl_base = BASE;
    logic req_ready, rsp_valid, mem_rd_en, fault;
    logic [31:0] rsp_paddr, mem_rd_addr, mem_rd_data;
    logic mem_rd_valid;
    logic [LAT-1:0] vpipe;
    logic [31:0] apipe [LAT];
    int nchecks = 0, nerr = 0;
    bit done = 0;
    int mv [NENT];
    int mcnt = 0;

    always #4 clk = ~clk;

    xlat_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .tbl_base(tbl_base), .flush_all(flush_all), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .fault(fault), .fault_ack(fault_ack)
    );

    function automatic logic [18:0] ppn_of(int v);
        return 19'((v * 37 + 5) & 32'h7FFFF);
    endfunction
    function automatic bit present(int v);
        return (v % 5) != 0;
    endfunction
    function automatic logic [31:0] pte_of(logic [31:0] a);
        int v;
        v = int'((a - BASE) >> 2);
        return {ppn_of(v), 12'hA5A, present(v)};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpipe <= '0;
        else begin
            vpipe <= {vpipe[LAT-2:0], mem_rd_en};
            apipe[0] <= mem_rd_addr;
            for (int k = 1; k < LAT; k++) apipe[k] <= apipe[k-1];
        end
    end
    assign mem_rd_valid = vpipe[LAT-1];
    assign mem_rd_data  = pte_of(apipe[LAT-1]);

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int mfind(int v);
        for (int i = 0; i < mcnt; i++) if (mv[i] == v) return i;
        return -1;
    endfunction
    task automatic mtouch(int idx);
        int v;
        v = mv[idx];
        for (int i = idx; i < mcnt - 1; i++) mv[i] = mv[i+1];
        mv[mcnt-1] = v;
    endtask
    task automatic minstall(int v);
        if (mcnt == NENT) begin
            for (int i = 0; i < NENT - 1; i++) mv[i] = mv[i+1];
            mv[NENT-1] = v;
        end else begin
            mv[mcnt] = v;
            mcnt++;
        end
    endtask

    function automatic int vpn_at(int k);
        return (k < 12) ? k : (32'h7FFE0 + k);
    endfunction

    task automatic lookup(int v, logic [12:0] off, bit noise);
        logic [31:0] va, exp_pa;
        int idx, c, extra;
        bit got;
        va = {19'(v), off};
        exp_pa = {ppn_of(v), off};
        idx = mfind(v);
        @(negedge clk);
        check(req_ready, "R9 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        #1;
        if (idx >= 0) begin
            check(rsp_valid && rsp_paddr == exp_pa, "R1 same-cycle hit (R2 any entry)",
                  {31'd0, rsp_valid, rsp_paddr}, {32'd1, exp_pa});
            mtouch(idx);
            @(negedge clk);
            req_valid = 1'b0;
            return;
        end
        check(!rsp_valid, "R7 expected miss", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        req_valid = noise;
        req_vaddr = va ^ 32'h00FF_E000;
        #1;
        check(mem_rd_en && mem_rd_addr == BASE + 32'(v) * 4, "R3 walk read",
              {31'd0, mem_rd_en, mem_rd_addr}, {32'd1, BASE + 32'(v) * 4});
        check(!req_ready, "R9 not ready in walk", 64'(req_ready), 64'd0);
        c = 1; extra = 0; got = 0;
        while (!got && c < 30) begin
            @(negedge clk);
            #1;
            c++;
            if (mem_rd_en) extra++;
            if (rsp_valid || fault) got = 1;
        end
        req_valid = 1'b0;
        check(extra == 0, "R9 stray request ignored", 64'(extra), 64'd0);
        check(c == LAT + 2, "R4 walk latency", 64'(c), 64'(LAT + 2));
        if (present(v)) begin
            check(rsp_valid && !fault && rsp_paddr == exp_pa, "R4 replay result",
                  {30'd0, fault, rsp_valid, rsp_paddr}, {32'd1, exp_pa});
            minstall(v);
            @(negedge clk);
        end else begin
            check(fault && !rsp_valid, "R5 fault on absent page",
                  {62'd0, fault, rsp_valid}, 64'd2);
            repeat (3) @(negedge clk);
            #1;
            check(fault && !req_ready, "R6 fault held", {62'd0, fault, req_ready}, 64'd2);
            fault_ack = 1'b1;
            @(negedge clk);
            fault_ack = 1'b0;
            #1;
            check(!fault && req_ready, "R6 fault cleared", {62'd0, fault, req_ready}, 64'd1);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    initial begin
        #3;
        check(req_ready && !rsp_valid && !fault && !mem_rd_en, "R10 reset outputs",
              {60'd0, req_ready, rsp_valid, fault, mem_rd_en}, 64'h8);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready && !rsp_valid && !fault && !mem_rd_en, "R10 after reset",
              {60'd0, req_ready, rsp_valid, fault, mem_rd_en}, 64'h8);
        // sweep every page twice
        for (int r = 0; r < 2; r++)
            for (int k = 0; k < 24; k++)
                lookup(vpn_at(k), 13'((k * 311 + r * 97) & 32'h1FFF), (k % 3) == 0);
        // stride pattern with irregular reuse distance
        for (int i = 0; i < 200; i++)
            lookup(vpn_at((i * 13 + (i / 7) * 3) % 24), 13'((i * 53) & 32'h1FFF), (i % 3) == 1);
        // R8: flush empties the buffer
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        mcnt = 0;
        for (int i = 0; i < 60; i++)
            lookup(vpn_at((i * 7 + 2) % 24), 13'((i * 977) & 32'h1FFF), (i % 4) == 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule